// File: doc/BRIEF.md
# Scan-Start Resynchronizing Conversion Clock Generator

This block divides the system clock into a conversion-clock tick shared by two converter channels, A and B. A free-running divider would force a freshly commanded scan to wait for the next period boundary, which can be several system clocks away. Here the divider phase is forced back to zero when a scan is launched from an idle state. The tick and the scan-start pulse then appear at once.

Each channel takes a scan request from a software start strobe or an external sync pulse. In the two common modes, sequential and simultaneous parallel, any request launches both channels together. In independent parallel mode each channel launches on its own request. Only a launch made while both channels are idle realigns the divider. A channel that starts while the other is already scanning waits for the next tick, unless its request lands exactly on a boundary.

Each channel holds a busy flag from its launch until its end-of-scan input. The divider runs only while at least one channel is busy.

Top module: `scan_clk_resync`

## Requirements
- R1: While rst_n is low and in the first cycle after it, conv_tick_o, both scan-go outputs and both busy outputs are 0.
- R2: The divide period is ratio_i clamped to the range 6 to 64 (values below 6 give 6, values above 64 give 64). While any channel is busy, conv_tick_o pulses once every period cycles.
- R3: When both channels are idle and no request is accepted, conv_tick_o stays 0.
- R4: A request accepted while both channels are idle realigns the divider. In the cycle after the strobe, conv_tick_o and the scan-go of each launched channel are 1. A start strobe and a sync pulse have the same effect.
- R5: When mode_i[1] is 0 (00 sequential, 01 simultaneous parallel), any request on either channel while both are idle launches both channels together and sets both busy flags. Requests made while either channel is busy are ignored.
- R6: When mode_i[1] is 1 (independent parallel), a request on an idle channel while the other channel is busy does not realign. The channel's scan-go pulses together with the next conv_tick_o pulse. Every scan-go pulse coincides with a conv_tick_o pulse.
- R7: In independent mode, if the second channel's request arrives in the last cycle of a divider period, its scan-go pulses in the next cycle, together with that tick, with no further delay.
- R8: In independent mode, requests on both channels in the same cycle while both are idle realign once and launch both channels in the next cycle.
- R9: A request on a channel whose busy flag is set produces no scan-go pulse and leaves the divider phase unchanged.
- R10: end-of-scan on a busy channel clears its busy flag in the next cycle and cancels a launch still waiting for a tick. Once both channels are idle the divider stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 sequential, 01 simultaneous parallel, 1x independent parallel |
| ratio_i | input | RW (7) | Requested conversion-clock period in system clocks |
| start_a_i | input | 1 | Software start strobe, channel A |
| start_b_i | input | 1 | Software start strobe, channel B |
| sync_a_i | input | 1 | External sync pulse, channel A |
| sync_b_i | input | 1 | External sync pulse, channel B |
| eos_a_i | input | 1 | End-of-scan, channel A |
| eos_b_i | input | 1 | End-of-scan, channel B |
| conv_tick_o | output | 1 | Conversion-clock tick, one cycle wide |
| scan_go_a_o | output | 1 | Scan-start pulse for channel A, aligned to a tick |
| scan_go_b_o | output | 1 | Scan-start pulse for channel B, aligned to a tick |
| busy_a_o | output | 1 | Channel A scanning |
| busy_b_o | output | 1 | Channel B scanning |

## Verification
The hardest case to reach is a second independent-mode request that lands exactly in the last cycle of a divider period. The delayed launch then has to collapse into an immediate one. Random strobes hit that cycle only rarely. A directed sequence therefore realigns channel A and waits exactly period minus one idle cycles before it pulses channel B. A long random run then mixes modes, ratios outside the legal range, collisions between end-of-scan and waiting launches, and simultaneous requests, and compares every cycle against a reference model in the bench.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ  = 2'b00,
        MODE_SIM  = 2'b01,
        MODE_IND  = 2'b10,
        MODE_IND2 = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic busy;
        logic pend;
        logic go;
    } chan_st_t;

endpackage

// File: rtl/scr_req_unit.sv
module scr_req_unit #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] start_i,
    input  logic [NCH-1:0] sync_i,
    input  logic [NCH-1:0] busy_i,
    input  logic           indep_i,
    output logic [NCH-1:0] accept_o
);
    logic [NCH-1:0] req;

    always_comb begin
        req = start_i | sync_i;
        if (indep_i) begin
            accept_o = req & ~busy_i;
        end else begin
            accept_o = {NCH{(|req) & ~(|busy_i)}};
        end
    end
endmodule

// File: rtl/scr_divider.sv
module scr_divider #(
    parameter int RW   = 7,
    parameter int MINP = 6,
    parameter int MAXP = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          realign_i,
    input  logic          run_i,
    input  logic [RW-1:0] ratio_i,
    output logic          tick_o,
    output logic          boundary_o
);
    localparam logic [RW-1:0] PMIN = RW'(MINP);
    localparam logic [RW-1:0] PMAX = RW'(MAXP);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [RW-1:0] per;
    logic [RW-1:0] last;
    logic          at_last;

    always_comb begin
        if (ratio_i < PMIN)      per = PMIN;
        else if (ratio_i > PMAX) per = PMAX;
        else                     per = ratio_i;
        last       = per - 1'b1;
        at_last    = (st_q.cnt >= last);
        boundary_o = run_i & at_last & ~realign_i;

        st_d = st_q;
        if (realign_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else if (run_i) begin
            if (at_last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.tick = 1'b0;
            end
        end else begin
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/scr_chan.sv
module scr_chan
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic realign_i,
    input  logic boundary_i,
    input  logic eos_i,
    output logic busy_o,
    output logic go_o
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d.go   = (accept_i & (realign_i | boundary_i))
                  | (st_q.pend & boundary_i & ~eos_i);
        st_d.pend = (accept_i & ~realign_i & ~boundary_i)
                  | (st_q.pend & ~boundary_i & ~eos_i);
        st_d.busy = accept_i | (st_q.busy & ~eos_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign go_o   = st_q.go;
endmodule

// File: rtl/scan_clk_resync.sv
module scan_clk_resync
    import scr_pkg::*;
#(
    parameter int RW   = 7,
    parameter int MINP = 6,
    parameter int MAXP = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [RW-1:0] ratio_i,
    input  logic          start_a_i,
    input  logic          start_b_i,
    input  logic          sync_a_i,
    input  logic          sync_b_i,
    input  logic          eos_a_i,
    input  logic          eos_b_i,
    output logic          conv_tick_o,
    output logic          scan_go_a_o,
    output logic          scan_go_b_o,
    output logic          busy_a_o,
    output logic          busy_b_o
);
    localparam int NCH = 2;

    scan_mode_e     mode;
    logic           indep;
    logic [NCH-1:0] start_v, sync_v, eos_v, busy_v, go_v, accept;
    logic           running, realign, boundary;

    always_comb begin
        mode    = scan_mode_e'(mode_i);
        indep   = (mode == MODE_IND) || (mode == MODE_IND2);
        start_v = {start_b_i, start_a_i};
        sync_v  = {sync_b_i, sync_a_i};
        eos_v   = {eos_b_i, eos_a_i};
        running = |busy_v;
        realign = (|accept) & ~running;
    end

    scr_req_unit #(.NCH(NCH)) u_req (
        .start_i  (start_v),
        .sync_i   (sync_v),
        .busy_i   (busy_v),
        .indep_i  (indep),
        .accept_o (accept)
    );

    scr_divider #(.RW(RW), .MINP(MINP), .MAXP(MAXP)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .realign_i  (realign),
        .run_i      (running),
        .ratio_i    (ratio_i),
        .tick_o     (conv_tick_o),
        .boundary_o (boundary)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        scr_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .accept_i   (accept[g]),
            .realign_i  (realign),
            .boundary_i (boundary),
            .eos_i      (eos_v[g]),
            .busy_o     (busy_v[g]),
            .go_o       (go_v[g])
        );
    end

    assign scan_go_a_o = go_v[0];
    assign scan_go_b_o = go_v[1];
    assign busy_a_o    = busy_v[0];
    assign busy_b_o    = busy_v[1];
endmodule

// File: rtl/scan_clk_resync_chk.sv
module scan_clk_resync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       start_a_i,
    input logic       start_b_i,
    input logic       sync_a_i,
    input logic       sync_b_i,
    input logic       eos_a_i,
    input logic       eos_b_i,
    input logic       conv_tick_o,
    input logic       scan_go_a_o,
    input logic       scan_go_b_o,
    input logic       busy_a_o,
    input logic       busy_b_o
);
    logic req_a, req_b;
    assign req_a = start_a_i | sync_a_i;
    assign req_b = start_b_i | sync_b_i;

    assert_go_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_go_a_o || scan_go_b_o) |-> conv_tick_o);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_a_o && !busy_b_o && !req_a && !req_b) |=> !conv_tick_o);

    assert_go_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_go_a_o |-> busy_a_o);

    assert_common_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && (req_a || req_b) && !busy_a_o && !busy_b_o)
        |=> (scan_go_a_o && scan_go_b_o && busy_a_o && busy_b_o));

    assert_eos_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_a_i && busy_a_o) |=> !busy_a_o);

    assert_idle_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && req_a && !busy_a_o && !busy_b_o) |=> (scan_go_a_o && conv_tick_o));
endmodule

bind scan_clk_resync scan_clk_resync_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .start_a_i   (start_a_i),
    .start_b_i   (start_b_i),
    .sync_a_i    (sync_a_i),
    .sync_b_i    (sync_b_i),
    .eos_a_i     (eos_a_i),
    .eos_b_i     (eos_b_i),
    .conv_tick_o (conv_tick_o),
    .scan_go_a_o (scan_go_a_o),
    .scan_go_b_o (scan_go_b_o),
    .busy_a_o    (busy_a_o),
    .busy_b_o    (busy_b_o)
);

// File: tb/scan_clk_resync_tb_top.sv
module scan_clk_resync_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [6:0] ratio = 7'd6;
    logic sa = 0, sb = 0, ya = 0, yb = 0, ea = 0, eb = 0;
    logic tick, go_a, go_b, bz_a, bz_b;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic       m_tick;
    int         m_cnt;
    logic [1:0] m_busy, m_pend, m_go;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_clk_resync dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ratio_i(ratio),
        .start_a_i(sa), .start_b_i(sb), .sync_a_i(ya), .sync_b_i(yb),
        .eos_a_i(ea), .eos_b_i(eb),
        .conv_tick_o(tick), .scan_go_a_o(go_a), .scan_go_b_o(go_b),
        .busy_a_o(bz_a), .busy_b_o(bz_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_per(input int r);
        if (r < 6)  return 6;
        if (r > 64) return 64;
        return r;
    endfunction

    task automatic model_upd();
        logic [1:0] req, acc;
        logic running, realign, bnd;
        req = {sb | yb, sa | ya};
        running = |m_busy;
        if (mode[1]) acc = req & ~m_busy;
        else         acc = ((|req) && !(|m_busy)) ? 2'b11 : 2'b00;
        realign = (|acc) && !running;
        bnd = running && (m_cnt >= eff_per(int'(ratio)) - 1) && !realign;
        for (int i = 0; i < 2; i++) begin
            logic e;
            e = (i == 0) ? ea : eb;
            m_go[i]   = (acc[i] && (realign || bnd)) || (m_pend[i] && bnd && !e);
            m_pend[i] = (acc[i] && !realign && !bnd) || (m_pend[i] && !bnd && !e);
            m_busy[i] = acc[i] || (m_busy[i] && !e);
        end
        if (realign)      begin m_cnt = 0; m_tick = 1; end
        else if (running) begin
            if (bnd) begin m_cnt = 0; m_tick = 1; end
            else     begin m_cnt = m_cnt + 1; m_tick = 0; end
        end else m_tick = 0;
    endtask

    task automatic step(input logic i_sa, input logic i_sb, input logic i_ya,
                        input logic i_yb, input logic i_ea, input logic i_eb);
        @(negedge clk);
        sa = i_sa; sb = i_sb; ya = i_ya; yb = i_yb; ea = i_ea; eb = i_eb;
        model_upd();
        @(posedge clk);
        #1;
        chk(tick == m_tick, "R2", "tick vs model", int'(tick), int'(m_tick));
        chk({go_b, go_a} == m_go, "R6", "scan-go vs model", int'({go_b, go_a}), int'(m_go));
        chk({bz_b, bz_a} == m_busy, "R9", "busy vs model", int'({bz_b, bz_a}), int'(m_busy));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic measure(input int r);
        int n;
        ratio = 7'(r);
        step(1, 0, 0, 0, 0, 0);
        n = 0;
        do begin step(0, 0, 0, 0, 0, 0); n++; end while (!tick && n < 200);
        chk(n == eff_per(r), "R2", "tick spacing", n, eff_per(r));
        step(0, 0, 0, 0, 1, 1);
    endtask

    initial begin
        int w;
        void'($urandom(32'h5eed_0042));
        m_tick = 0; m_cnt = 0; m_busy = 0; m_pend = 0; m_go = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({tick, go_a, go_b, bz_a, bz_b} == 5'b0, "R1", "outputs in reset",
            int'({tick, go_a, go_b, bz_a, bz_b}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk({tick, go_a, go_b, bz_a, bz_b} == 5'b0, "R1", "outputs after reset",
            int'({tick, go_a, go_b, bz_a, bz_b}), 0);

        mode = 2'b10; ratio = 7'd6;
        step(0, 0, 1, 0, 0, 0);
        chk(tick && go_a && !go_b, "R4", "sync launch realigns",
            int'({tick, go_a, go_b}), 3'b110);
        idle(1);
        step(0, 1, 0, 0, 0, 0);
        chk(!go_b, "R6", "late start waits", int'(go_b), 0);
        w = 0;
        while (!go_b && w < 20) begin step(0, 0, 0, 0, 0, 0); w++; end
        chk(w == 4 && tick, "R6", "late start waits to tick", w, 4);

        step(0, 0, 0, 0, 1, 1);
        chk(!bz_a && !bz_b, "R10", "eos clears busy", int'({bz_a, bz_b}), 0);
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 0, 0, 0);
            chk(!tick, "R3", "idle no tick", int'(tick), 0);
        end

        step(1, 0, 0, 0, 0, 0);
        idle(5);
        step(0, 1, 0, 0, 0, 0);
        chk(go_b && tick, "R7", "start on boundary", int'({go_b, tick}), 3);
        step(0, 0, 0, 0, 1, 1);

        step(1, 1, 0, 0, 0, 0);
        chk(go_a && go_b && tick, "R8", "dual idle start", int'({go_a, go_b, tick}), 7);
        step(1, 0, 0, 0, 0, 0);
        chk(!go_a && !tick, "R9", "busy start ignored", int'({go_a, tick}), 0);
        step(0, 0, 0, 0, 1, 1);

        mode = 2'b00;
        step(0, 0, 0, 1, 0, 0);
        chk(go_a && go_b && bz_a && bz_b, "R5", "common launch",
            int'({go_a, go_b, bz_a, bz_b}), 15);
        step(0, 0, 0, 0, 1, 1);
        mode = 2'b01;
        step(1, 0, 0, 0, 0, 0);
        chk(go_a && go_b, "R5", "simultaneous launch", int'({go_a, go_b}), 3);
        step(0, 0, 0, 0, 1, 1);

        mode = 2'b10;
        measure(3);
        measure(100);
        measure(20);

        for (int i = 0; i < 6000; i++) begin
            if (i % 300 == 0) begin
                mode  = 2'($urandom_range(0, 3));
                ratio = 7'($urandom_range(0, 80));
            end
            step($urandom_range(0, 14) == 0, $urandom_range(0, 14) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 39) == 0, $urandom_range(0, 39) == 0);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule